// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits over a sequence of clock cycles, using a single adder. A start pulse captures both operands. The multiplicand is kept in its own register. The multiplier goes into a low register that shifts. A high accumulator, plus a carry flag above it, collects the partial products. Each step has two parts. First, if the lowest bit of the low register is set, the multiplicand is added into the accumulator. Second, the carry flag, the accumulator and the low register move right by one place as one long register.

A down-counter starts at `WIDTH` and steps down once per shift. When it runs out, the block returns to idle and raises `done` for one cycle. The full-width product is the accumulator followed by the low register, and it stays on the output until the next accepted start. A caller pulses `start` while `busy` is low, waits for `done`, and then reads `product`.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is low captures `op_a` and `op_b`, and `busy` is 1 from the next cycle until the result is ready.
- R3: `product` equals the unsigned product `op_a * op_b` (2·WIDTH bits) of the captured operands, for every operand pair.
- R4: `done` rises exactly 2·WIDTH clock edges after the edge that accepted `start`, it is high for exactly one cycle, and `busy` is 0 in that cycle.
- R5: A `start` sampled while `busy` is 1 is ignored: the running operation finishes with its original operands and with unchanged latency.
- R6: Changes on `op_a` and `op_b` after the capturing edge have no effect on the result, and `product` holds its value while idle until the next accepted start.
- R7: An addition whose result overflows the accumulator keeps its carry, so the all-ones operands give (2^WIDTH−1)^2.
- R8: A zero operand on either side gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiplication |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| product | output | 2*WIDTH | Result, accumulator over low register |

## Verification
The assertions assume that `start` is a clean synchronous level that changes only away from the rising edge. They also assume that reset is held for at least one edge before any start. The bench drives every input at the falling edge and leaves reset long before the first request. It deliberately raises `start` and scrambles the operands in the middle of a run. This checks that the in-flight assertions on counter and state progress still hold when the environment misbehaves within those limits.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADD   = 2'd1,
    ST_SHIFT = 2'd2
  } mul_state_e;
endpackage

// File: rtl/shift_add_mul_ctrl.sv
module shift_add_mul_ctrl
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic add_en,
  output logic shift_en,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WIDTH + 1);

  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    load_en  = 1'b0;
    add_en   = 1'b0;
    shift_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          cnt_d   = CW'(WIDTH);
          state_d = ST_ADD;
        end
      end
      ST_ADD: begin
        add_en  = 1'b1;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        shift_en = 1'b1;
        cnt_d    = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_ADD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state_q == ST_ADD) |=> (state_q == ST_SHIFT));
endmodule

// File: rtl/shift_add_mul_datapath.sv
module shift_add_mul_datapath #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               add_en,
  input  logic               shift_en,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] m_q, m_d;
  logic [WIDTH-1:0] acc_q, acc_d;
  logic [WIDTH-1:0] low_q, low_d;
  logic             cy_q, cy_d;
  logic [WIDTH:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, m_q};

  always_comb begin
    m_d   = m_q;
    acc_d = acc_q;
    low_d = low_q;
    cy_d  = cy_q;
    if (load_en) begin
      m_d   = mcand;
      low_d = mplier;
      acc_d = '0;
      cy_d  = 1'b0;
    end else if (add_en) begin
      if (low_q[0]) begin
        {cy_d, acc_d} = sum;
      end
    end else if (shift_en) begin
      {cy_d, acc_d, low_d} = {1'b0, cy_q, acc_q, low_q[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q   <= '0;
      acc_q <= '0;
      low_q <= '0;
      cy_q  <= 1'b0;
    end else begin
      if (load_en) m_q <= m_d;
      if (load_en || add_en || shift_en) begin
        acc_q <= acc_d;
        low_q <= low_d;
        cy_q  <= cy_d;
      end
    end
  end

  assign product = PW'({acc_q, low_q});

  a_r6_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !add_en && !shift_en) |=> $stable(product));
  a_r6_mcand_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(m_q));
  a_r7_skip_add: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !low_q[0]) |=> ($stable(acc_q) && $stable(cy_q)));
  a_r7_carry_shifted_out: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (acc_q[WIDTH-1] == $past(cy_q)));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic load_en, add_en, shift_en;

  shift_add_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load_en  (load_en),
    .add_en   (add_en),
    .shift_en (shift_en),
    .busy     (busy),
    .done     (done)
  );

  shift_add_mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .add_en   (add_en),
    .shift_en (shift_en),
    .mcand    (op_a),
    .mplier   (op_b),
    .product  (product)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   op_a = '0;
  logic [W-1:0]   op_b = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  shift_add_mul #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [2*W-1:0] acc = '0;
    for (int i = 0; i < W; i++)
      if (y[i]) acc = acc + ({{W{1'b0}}, x} << i);
    return acc;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_mul(input logic [W-1:0] x, input logic [W-1:0] y,
                        input bit poke, input string tag);
    int n;
    logic [2*W-1:0] hold;
    @(negedge clk);
    op_a = x; op_b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    n = 0;
    while (!done && n < 4*W + 10) begin
      if (poke && n == 3) begin
        start = 1'b1; op_a = ~x; op_b = ~y;
      end else if (poke && n == 4) begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == 2*W, "R4 latency", n, 2*W);
    chk(product == ref_mul(x, y), tag, product, ref_mul(x, y));
    chk(busy == 1'b0, "R4 idle at done", busy, 0);
    hold = product;
    op_a = x ^ 8'h5A; op_b = y ^ 8'hA5;
    @(negedge clk);
    chk(done == 1'b0, "R4 done one cycle", done, 0);
    @(negedge clk);
    chk(product == hold, "R6 product held", product, hold);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(product == '0, "R1 product", product, 0);

    do_mul(8'd0, 8'd173, 1'b0, "R8 zero multiplicand");
    do_mul(8'd201, 8'd0, 1'b0, "R8 zero multiplier");
    do_mul(8'hFF, 8'hFF, 1'b0, "R7 all ones");
    do_mul(8'hFF, 8'h01, 1'b0, "R3 times one");
    do_mul(8'h80, 8'h80, 1'b0, "R3 top bits");
    do_mul(8'd37, 8'd91, 1'b1, "R5 start while busy");
    do_mul(8'hF0, 8'hEE, 1'b1, "R6 operand change");
    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      y = W'($urandom);
      do_mul(x, y, (k % 5) == 0, "R3 random product");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule